// File: doc/BRIEF.md
# Packed Complex Multiplier with Fractional Rounding

This unit multiplies two complex numbers held in fixed-point form. Each operand word carries a real and an imaginary part as two signed halfwords. For each part of the product the unit forms two halfword-by-halfword products and adds or subtracts them. It can double the result as a fractional-format correction, then rounds to nearest by adding half of the lower halfword's weight. It clamps the sum to the signed full-word range and returns only the upper halfword. The two parts are packed back into one word.

The datapath has one register stage. An operation is offered with `in_valid`, and its result and `out_valid` appear on the next clock. A sticky flag records that at least one part has clipped since it was last cleared. Software-style polling of that flag is left to the surrounding logic. The flag is cleared through a dedicated input.

Top module: `cplx_mul_rnd`

## Requirements
- R1: Bits [HW-1:0] of each operand hold the signed real part and bits [2*HW-1:HW] the signed imaginary part. The result real part, in bits [HW-1:0], is built from ar*br − ai*bi.
- R2: The result imaginary part, in bits [2*HW-1:HW], is built from ar*bi + ai*br. It is computed at the same time as the real part, in an identical datapath.
- R3: When `shift_en` is 1 the combined products are doubled before rounding. When it is 0 they are not.
- R4: Rounding adds 2^(HW−1) (0x8000 for HW=16) to the combined value. The part returned is bits [2*HW-1:HW] of the saturated sum.
- R5: A rounded sum above 2^(2*HW−1)−1 is clamped to that value, so the part reads 0x7FFF. For example, (−32768)×(−32768) with doubling gives 0x7FFF.
- R6: A rounded sum below −2^(2*HW−1) is clamped to that value, so the part reads 0x8000.
- R7: `out_valid` equals `in_valid` of the previous clock. `out_data` then holds the result of the operands presented in that clock.
- R8: `sat_sticky` goes to 1 on the clock whose result has either part clipped. It stays 1 until cleared.
- R9: `sat_clr` high at a clock edge with no clipping result clears `sat_sticky` on that edge.
- R10: When `sat_clr` and a clipping valid operation meet on the same edge, the flag ends up 1.
- R11: While `in_valid` is low, `out_data` keeps its last value.
- R12: A synchronous low `rst_n` sets `out_data` to 0, `out_valid` to 0 and `sat_sticky` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| shift_en | input | 1 | Double the combined products before rounding |
| op_a | input | 2*HW | Packed complex operand A (imaginary high, real low) |
| op_b | input | 2*HW | Packed complex operand B (imaginary high, real low) |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| out_data | output | 2*HW | Packed rounded complex result |
| sat_sticky | output | 1 | Set when any part has clipped since last clear |

## Verification
The bench builds the unit with the default HW=16, so the real 16-bit fractional corner values can be reached. These include the most negative halfword squared with doubling, where a single product alone overflows. They also include sums that land exactly on the rounding boundary. At this width the bench's 64-bit integer model holds every intermediate value without loss. That makes both clamp directions, the carry from the rounding constant, and same-edge interplay between clearing and setting the flag directly checkable against arithmetic computed from the requirements.

// File: rtl/cplx_mul_pkg.sv
// Shared definitions for the packed complex multiplier.
// Assumes nothing beyond being compiled before the modules that import it.
package cplx_mul_pkg;

    // How the two products of one result part are combined.
    typedef enum logic {
        COMB_SUB = 1'b0,
        COMB_ADD = 1'b1
    } comb_op_e;

endpackage

// File: rtl/cplx_prod_pair.sv
// Forms one result part before rounding: x0*y0 (+/-) x1*y1, optionally doubled.
// Assumes signed two's-complement halfword inputs; the output is wide enough
// that neither the doubling nor the combination can wrap.
module cplx_prod_pair
    import cplx_mul_pkg::*;
#(
    parameter int       HW = 16,
    parameter comb_op_e OP = COMB_ADD
) (
    input  logic signed [HW-1:0]     x0,
    input  logic signed [HW-1:0]     y0,
    input  logic signed [HW-1:0]     x1,
    input  logic signed [HW-1:0]     y1,
    input  logic                     dbl,
    output logic signed [2*HW+1:0]   comb
);
    localparam int PW = 2 * HW;
    localparam int AW = PW + 2;

    logic signed [PW-1:0] prod0, prod1;
    logic signed [AW-1:0] ext0, ext1, sh0, sh1;

    // Full-precision signed halfword products.
    always_comb begin
        prod0 = x0 * y0;
        prod1 = x1 * y1;
    end

    // Sign-extend to the working width, then apply the optional doubling.
    always_comb begin
        ext0 = {{(AW-PW){prod0[PW-1]}}, prod0};
        ext1 = {{(AW-PW){prod1[PW-1]}}, prod1};
        sh0  = dbl ? {ext0[AW-2:0], 1'b0} : ext0;
        sh1  = dbl ? {ext1[AW-2:0], 1'b0} : ext1;
    end

    // Combination picked at elaboration from the part's role.
    generate
        if (OP == COMB_ADD) begin : g_add
            assign comb = sh0 + sh1;
        end else begin : g_sub
            assign comb = sh0 - sh1;
        end
    endgenerate

endmodule

// File: rtl/cplx_rnd_sat.sv
// Rounds a combined part by adding half an LSB of the kept halfword,
// clamps to the signed full-word range and returns the upper halfword.
// Assumes the input is the sign-correct combined value from cplx_prod_pair.
module cplx_rnd_sat #(
    parameter int HW = 16
) (
    input  logic signed [2*HW+1:0] comb,
    output logic        [HW-1:0]   part,
    output logic                   clip
);
    localparam int PW = 2 * HW;
    localparam int AW = PW + 2;
    localparam int RW = AW + 1;

    localparam logic signed [RW-1:0] RND  = {{(RW-HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};
    localparam logic signed [RW-1:0] MAXV = {{(RW-PW+1){1'b0}}, {(PW-1){1'b1}}};
    localparam logic signed [RW-1:0] MINV = {{(RW-PW+1){1'b1}}, {(PW-1){1'b0}}};

    logic signed [RW-1:0] rounded;
    logic signed [RW-1:0] clamped;
    logic                 over_hi, over_lo;

    // Add the rounding constant with one spare bit so the carry is kept.
    always_comb rounded = {comb[AW-1], comb} + RND;

    // Compare against the full-word limits and clamp.
    always_comb begin
        over_hi = rounded > MAXV;
        over_lo = rounded < MINV;
        if (over_hi)      clamped = MAXV;
        else if (over_lo) clamped = MINV;
        else              clamped = rounded;
    end

    // Keep only the upper halfword of the clamped full word.
    always_comb begin
        part = clamped[PW-1:HW];
        clip = over_hi | over_lo;
    end

endmodule

// File: rtl/cplx_mul_rnd.sv
// Packed complex multiplier with optional doubling, rounding and saturation.
// Real part in the low halfword, imaginary part in the high halfword.
// One register stage: result and valid appear one clock after in_valid.
// Assumes synchronous active-low reset and a single clock domain.
module cplx_mul_rnd
    import cplx_mul_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              shift_en,
    input  logic [2*HW-1:0]   op_a,
    input  logic [2*HW-1:0]   op_b,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic [2*HW-1:0]   out_data,
    output logic              sat_sticky
);
    localparam int NPART = 2;
    localparam int AW    = 2 * HW + 2;

    logic signed [HW-1:0] a_re, a_im, b_re, b_im;
    logic signed [HW-1:0] px0 [NPART];
    logic signed [HW-1:0] py0 [NPART];
    logic signed [HW-1:0] px1 [NPART];
    logic signed [HW-1:0] py1 [NPART];
    logic signed [AW-1:0] comb [NPART];
    logic [HW-1:0]        part [NPART];
    logic [NPART-1:0]     clip;
    logic                 clip_any;

    // Unpack operand halves.
    always_comb begin
        a_re = op_a[HW-1:0];
        a_im = op_a[2*HW-1:HW];
        b_re = op_b[HW-1:0];
        b_im = op_b[2*HW-1:HW];
    end

    // Route operands: part 0 is real (ar*br - ai*bi), part 1 imaginary (ar*bi + ai*br).
    always_comb begin
        px0[0] = a_re; py0[0] = b_re; px1[0] = a_im; py1[0] = b_im;
        px0[1] = a_re; py0[1] = b_im; px1[1] = a_im; py1[1] = b_re;
    end

    // Identical datapath per part; only the combine operation differs.
    generate
        for (genvar g = 0; g < NPART; g++) begin : g_part
            localparam comb_op_e OPG = (g == 0) ? COMB_SUB : COMB_ADD;
            cplx_prod_pair #(.HW(HW), .OP(OPG)) u_pp (
                .x0   (px0[g]),
                .y0   (py0[g]),
                .x1   (px1[g]),
                .y1   (py1[g]),
                .dbl  (shift_en),
                .comb (comb[g])
            );
            cplx_rnd_sat #(.HW(HW)) u_rs (
                .comb (comb[g]),
                .part (part[g]),
                .clip (clip[g])
            );
        end
    endgenerate

    // Any part clipping on a valid operation.
    always_comb clip_any = in_valid & (|clip);

    // Output register: capture result on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= {part[1], part[0]};
        end
    end

    // Sticky saturation flag: a new clip wins over a same-edge clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sat_sticky <= 1'b0;
        else        sat_sticky <= (sat_sticky & ~sat_clr) | clip_any;
    end

endmodule

// File: rtl/cplx_mul_rnd_chk.sv
// Port-level temporal checks for cplx_mul_rnd, attached by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module cplx_mul_rnd_chk #(
    parameter int HW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            sat_clr,
    input logic            out_valid,
    input logic [2*HW-1:0] out_data,
    input logic            sat_sticky
);

    // Valid strobe delayed by exactly one clock.
    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // Result held while no operation is taken.
    assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data));

    // Flag stays set until a clear arrives.
    assert_sticky_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sat_sticky) && !$past(sat_clr)) |-> sat_sticky);

    // Flag can only rise alongside a delivered result.
    assert_sticky_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(sat_sticky)) |-> out_valid);

    // A clear with no operation leaves the flag low.
    assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sat_clr) && !$past(in_valid)) |-> !sat_sticky);

endmodule

bind cplx_mul_rnd cplx_mul_rnd_chk #(.HW(HW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .sat_clr    (sat_clr),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .sat_sticky (sat_sticky)
);

// File: tb/cplx_mul_rnd_tb.sv
`timescale 1ns/1ps
module cplx_mul_rnd_tb;
    localparam int HW = 16;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        shift_en = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        sat_clr = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        sat_sticky;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb[$];
    logic model_stk = 1'b0;
    logic [31:0] last_data = '0;
    string stk_tag = "R8";

    always #2.5 clk = ~clk;

    cplx_mul_rnd #(.HW(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .shift_en(shift_en),
        .op_a(op_a), .op_b(op_b), .sat_clr(sat_clr), .out_valid(out_valid),
        .out_data(out_data), .sat_sticky(sat_sticky)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Reference for one part from the requirements, in 64-bit integers.
    function automatic void ref_part(input longint p0, input longint p1, input bit sub,
                                     input bit dbl, output logic [15:0] hi, output bit clp);
        longint v;
        logic [31:0] w;
        v = sub ? (p0 - p1) : (p0 + p1);
        if (dbl) v = v * 2;
        v = v + 32768;
        clp = 1'b0;
        if (v > 64'sd2147483647)  begin v = 64'sd2147483647;  clp = 1'b1; end
        if (v < -64'sd2147483648) begin v = -64'sd2147483648; clp = 1'b1; end
        w  = v[31:0];
        hi = w[31:16];
    endfunction

    // Driver: one clock per call; pushes the expected result to the scoreboard.
    task automatic step(bit v, bit sh, logic [31:0] a, logic [31:0] b, bit clr, string tag);
        longint ar, ai, br, bi;
        logic [15:0] re, im;
        bit c0, c1;
        logic nstk;
        @(negedge clk);
        in_valid = v; shift_en = sh; op_a = a; op_b = b; sat_clr = clr;
        ar = longint'($signed(a[15:0])); ai = longint'($signed(a[31:16]));
        br = longint'($signed(b[15:0])); bi = longint'($signed(b[31:16]));
        ref_part(ar*br, ai*bi, 1'b1, sh, re, c0);
        ref_part(ar*bi, ai*br, 1'b0, sh, im, c1);
        nstk = (model_stk & ~clr) | (v & (c0 | c1));
        @(posedge clk);
        #1;
        model_stk = nstk;
        stk_tag = tag;
        if (v) sb.push_back('{data: {im, re}, tag: tag});
        in_valid = 1'b0; sat_clr = 1'b0;
    endtask

    // Monitor: compares results, hold behaviour and the sticky flag.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, out_data, e.data);
                    last_data = e.data;
                end
            end else begin
                check("R11 hold", out_data, last_data);
            end
            check({stk_tag, " sticky"}, {31'd0, sat_sticky}, {31'd0, model_stk});
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 out_valid", {31'd0, out_valid}, 32'd0);
        check("R12 out_data", out_data, 32'd0);
        check("R12 sat_sticky", {31'd0, sat_sticky}, 32'd0);
        rst_n = 1'b1;

        // R1 real part, imaginary zero, with and without doubling (R3)
        step(1, 1, 32'h0000_4000, 32'h0000_4000, 0, "R1");
        step(1, 0, 32'h0000_4000, 32'h0000_4000, 0, "R3");
        step(1, 1, 32'h2000_0000, 32'h1000_0000, 0, "R1");
        // R2 imaginary part, mixed signs
        step(1, 1, 32'h2000_1000, 32'h0400_0300, 0, "R2");
        step(1, 0, 32'hE000_3000, 32'h0400_F300, 0, "R2");
        step(1, 1, 32'h7FFF_8001, 32'h1234_EDCC, 0, "R3");
        // R4 rounding boundary: 3*0x4000 = 0xC000, +0x8000 carries into high half
        step(1, 0, 32'h0000_0003, 32'h0000_4000, 0, "R4");
        step(1, 0, 32'h0000_0001, 32'h0000_4000, 0, "R4");
        step(1, 0, 32'h0000_FFFF, 32'h0000_4000, 0, "R4");
        step(0, 0, 32'h0, 32'h0, 0, "R11");
        step(0, 0, 32'h0, 32'h0, 0, "R11");
        // R5 positive clamp: most negative squared with doubling
        step(1, 1, 32'h0000_8000, 32'h0000_8000, 0, "R5");
        step(1, 0, 32'h8000_8000, 32'h8000_8000, 0, "R5");
        // R9 clear with no operation
        step(0, 0, 32'h0, 32'h0, 1, "R9");
        step(1, 0, 32'h0100_0100, 32'h0100_0100, 0, "R9");
        // R6 negative clamp in the imaginary part
        step(1, 1, 32'h8000_8000, 32'h7FFF_7FFF, 0, "R6");
        // R10 clear and clipping operation on the same edge
        step(1, 1, 32'h0000_8000, 32'h0000_8000, 1, "R10");
        step(0, 0, 32'h0, 32'h0, 0, "R10");
        step(1, 0, 32'h0010_0010, 32'h0010_0010, 1, "R9");
        // R7 back-to-back burst of varied operands
        for (int i = 0; i < 60; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if (i % 7 == 0) ra[15:0] = 16'h8000;
            step(1, i[0], ra, rb, (i % 11 == 5), "R7");
            if (i % 9 == 4) step(0, 0, 32'h0, 32'h0, 0, "R11");
        end
        step(0, 0, 32'h0, 32'h0, 0, "R7");
        step(0, 0, 32'h0, 32'h0, 0, "R7");
        check("R7 drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule